// File: doc/BRIEF.md
# I2C Register-Access Target

This block is a target on a two-wire I2C bus that opens a window onto a register file of 128 byte-wide entries kept outside the block. Clock and data lines arrive as plain inputs. The data line leaves as a pull-low enable, and the bus pull-up supplies the high level. Both lines are brought into the system clock through two-stage synchronisers. Bus events are found by comparing successive samples, so the bus clock never clocks any flop.

A controller first sends the device address with the write direction. It then sends one pointer byte, whose low seven bits pick a register and whose top bit chooses whether the pointer advances after every data byte. Each data byte that follows becomes a one-cycle write strobe on the register-file port. To read, the controller issues a repeated START and the device address with the read direction. The target then drives bytes from the register file for as long as the controller acknowledges them. The pointer and the advance mode persist from one transaction to the next.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and `reg_we` is 0.
- R2: A first byte whose top seven bits equal `DEV_ADDR` is acknowledged: SDA is pulled low during the ninth clock. For any other address, SDA stays released for the rest of the transaction and no register is written.
- R3: Bytes are sent MSB first, and bit 0 of the address byte selects read (1) or write (0). In a write, the target acknowledges the pointer byte and every data byte. Each data byte gives exactly one single-cycle `reg_we` pulse, carrying that byte on `reg_wdata` and the current pointer on `reg_addr`.
- R4: When bit 7 of the pointer byte is 0, every data byte of the transaction, written or read, uses the register selected by bits 6..0.
- R5: When bit 7 of the pointer byte is 1, the pointer advances by one after each data byte written or read, and 127 wraps to 0.
- R6: After a repeated START and the address with the read bit, the target drives register bytes MSB first. A controller ACK (SDA low in the ninth clock) asks for the next byte. A controller NACK makes the target release SDA and stay silent until the next START.
- R7: The pointer and the advance mode are kept across repeated STARTs and STOPs. A read that starts without a pointer byte continues from where the last transfer left the pointer.
- R8: A START in the middle of a byte restarts address reception. A STOP in the middle of a byte returns the target to idle, and the partial byte is not written.
- R9: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. The target changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | 7 | Register-file address (current pointer) |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Register-file read data for `reg_addr`, combinational |

## Verification
The hardest cases to reach from the ports are a bus condition that cuts into a byte, and pointer wrap during a burst. Reaching them needs a bus line to move at an exact bit position, which byte-level stimulus cannot do. The bench therefore drives the bus one bit at a time. It aborts an address byte after four bits with a repeated START, and it ends a data byte after four bits with a STOP. It then reads the register back to show that the partial byte left no trace. It also starts advancing bursts at registers 126 and 127, so that both writes and reads cross the wrap point. A final read with no pointer byte shows where the pointer came to rest.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_DEV_ACK,
    ST_SUBADDR,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WD_ACK,
    ST_RDATA,
    ST_RD_ACK,
    ST_RD_NEXT
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_line_sync.sv
module i2c_tgt_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[SYNC_STAGES-1];
      sda_d    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7,
  parameter logic [DW-2:0] DEV_ADDR = 7'h2A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata
);
  localparam int CW = $clog2(DW);

  tgt_state_e    st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [DW-1:0] sh, sh_n, wd, wd_n, byte_in;
  logic [AW-1:0] ptr, ptr_n;
  logic          ph, ph_n, oe, oe_n, inc, inc_n, rw, rw_n, we, we_n;
  logic          last, load;

  always_comb begin
    st_n = st; cnt_n = cnt; sh_n = sh; ph_n = ph; oe_n = oe;
    ptr_n = ptr; inc_n = inc; rw_n = rw; we_n = 1'b0; wd_n = wd;
    byte_in = {sh[DW-2:0], sda_s};
    last    = (cnt == CW'(DW-1));
    load    = 1'b0;
    if (we) ptr_n = ptr + AW'(inc);
    if (start_det) begin
      st_n = ST_DEVADDR; cnt_n = '0; ph_n = 1'b0; oe_n = 1'b0;
    end else if (stop_det) begin
      st_n = ST_IDLE; ph_n = 1'b0; oe_n = 1'b0;
    end else begin
      case (st)
        ST_DEVADDR, ST_SUBADDR, ST_WDATA: begin
          if (scl_rise) begin
            sh_n  = byte_in;
            cnt_n = cnt + 1'b1;
            if (last) begin
              cnt_n = '0;
              case (st)
                ST_DEVADDR: begin
                  if (byte_in[DW-1:1] == DEV_ADDR) begin
                    st_n = ST_DEV_ACK; rw_n = byte_in[0];
                  end else begin
                    st_n = ST_IDLE;
                  end
                end
                ST_SUBADDR: begin
                  st_n = ST_SUB_ACK; ptr_n = byte_in[AW-1:0]; inc_n = byte_in[DW-1];
                end
                default: begin
                  st_n = ST_WD_ACK; we_n = 1'b1; wd_n = byte_in;
                end
              endcase
            end
          end
        end
        ST_DEV_ACK, ST_SUB_ACK, ST_WD_ACK: begin
          if (scl_fall) begin
            if (!ph) begin
              ph_n = 1'b1; oe_n = 1'b1;
            end else begin
              ph_n = 1'b0; oe_n = 1'b0;
              if (st == ST_DEV_ACK && rw) begin
                st_n = ST_RDATA; load = 1'b1;
              end else if (st == ST_DEV_ACK) begin
                st_n = ST_SUBADDR;
              end else begin
                st_n = ST_WDATA;
              end
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_n = cnt + 1'b1;
            if (last) begin
              cnt_n = '0; st_n = ST_RD_ACK;
            end
          end else if (scl_fall) begin
            sh_n = {sh[DW-2:0], 1'b0};
            oe_n = ~sh[DW-2];
          end
        end
        ST_RD_ACK: begin
          if (scl_fall) oe_n = 1'b0;
          else if (scl_rise) st_n = sda_s ? ST_IDLE : ST_RD_NEXT;
        end
        ST_RD_NEXT: begin
          if (scl_fall) begin
            st_n = ST_RDATA; load = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (load) begin
      sh_n  = reg_rdata;
      oe_n  = ~reg_rdata[DW-1];
      ptr_n = ptr + AW'(inc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; ph <= 1'b0; oe <= 1'b0;
      ptr <= '0; inc <= 1'b0; rw <= 1'b0; we <= 1'b0; wd <= '0;
    end else begin
      st <= st_n; cnt <= cnt_n; sh <= sh_n; ph <= ph_n; oe <= oe_n;
      ptr <= ptr_n; inc <= inc_n; rw <= rw_n; we <= we_n; wd <= wd_n;
    end
  end

  assign sda_oe    = oe;
  assign reg_addr  = ptr;
  assign reg_wdata = wd;
  assign reg_we    = we;

  assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe) |-> !scl_s);
  assert_we_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);
  assert_ptr_advance_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && inc) |=> (ptr == $past(ptr) + AW'(1)));
  assert_drive_only_addressed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (st inside {ST_DEV_ACK, ST_SUB_ACK, ST_WD_ACK, ST_RDATA, ST_RD_ACK}));
  assert_start_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_DEVADDR && !oe));
  assert_stop_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE && !we));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter int DW = 8,
  parameter int AW = 7,
  parameter logic [DW-2:0] DEV_ADDR = 7'h2A,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  i2c_tgt_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_engine #(.DW(DW), .AW(AW), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_sync_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_oe(sda_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sync_n |=> (!sda_oe && !reg_we));
endmodule

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int Q = 10;

  typedef struct { logic [6:0] a; logic [7:0] d; } wr_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic c_scl_low = 1'b0, c_sda_low = 1'b0;
  logic scl, sda, sda_oe, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  logic [6:0] exp_ptr = '0;
  bit exp_inc = 1'b0;
  wr_t wq[$];
  int n_cmp = 0, n_err = 0, viol = 0;
  bit done = 1'b0, prev_scl = 1'b1, prev_oe = 1'b0;

  always #10 clk = ~clk;

  assign scl = ~c_scl_low;
  assign sda = ~(c_sda_low | sda_oe);
  assign reg_rdata = mem[reg_addr];

  i2c_reg_target #(.DEV_ADDR(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= init_val(i);
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compare each write strobe against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (wq.size() == 0) begin
        chk(1'b0, "R3", "unexpected write addr", int'(reg_addr), 0);
      end else begin
        wr_t e;
        e = wq.pop_front();
        chk(reg_addr == e.a && reg_wdata == e.d, "R3", "write addr/data",
            {reg_addr, reg_wdata}, {e.a, e.d});
      end
    end
    if (rst_n && scl && prev_scl && sda_oe != prev_oe) viol++;
    prev_scl = scl;
    prev_oe  = sda_oe;
  end

  task automatic wq_(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start();
    c_sda_low = 1'b0; wq_(); c_scl_low = 1'b0; wq_();
    c_sda_low = 1'b1; wq_(); c_scl_low = 1'b1; wq_();
  endtask
  task automatic bus_stop();
    c_sda_low = 1'b1; wq_(); c_scl_low = 1'b0; wq_(); c_sda_low = 1'b0; wq_();
  endtask
  task automatic put_bit(input bit b);
    c_sda_low = ~b; wq_(); c_scl_low = 1'b0; wq_(); wq_(); c_scl_low = 1'b1; wq_();
  endtask
  task automatic get_bit(output bit b);
    c_sda_low = 1'b0; wq_(); c_scl_low = 1'b0; wq_(); b = sda; wq_(); c_scl_low = 1'b1; wq_();
  endtask
  task automatic put_byte(input logic [7:0] v, output bit ack);
    bit nak;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(nak);
    ack = ~nak;
  endtask
  task automatic get_byte(output logic [7:0] v, input bit mack);
    bit b;
    v = '0;
    for (int i = 0; i < 8; i++) begin get_bit(b); v = {v[6:0], b}; end
    put_bit(~mack);
  endtask

  // driver: write transaction, pushes expected strobes
  task automatic txn_write(input string req, input logic [7:0] sub, input int n,
                           input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    bit ack;
    logic [7:0] d;
    bus_start();
    put_byte({DEV, 1'b0}, ack); chk(ack, "R2", "address ACK", ack, 1);
    put_byte(sub, ack);         chk(ack, "R3", "pointer ACK", ack, 1);
    exp_ptr = sub[6:0]; exp_inc = sub[7];
    for (int k = 0; k < n; k++) begin
      d = (k == 0) ? b0 : (k == 1) ? b1 : b2;
      wq.push_back('{exp_ptr, d});
      exp_mem[exp_ptr] = d;
      put_byte(d, ack); chk(ack, req, "data ACK", ack, 1);
      if (exp_inc) exp_ptr = exp_ptr + 7'd1;
    end
    bus_stop();
  endtask

  task automatic txn_read(input string req, input bit with_sub, input logic [7:0] sub, input int n);
    bit ack;
    logic [7:0] v;
    bus_start();
    if (with_sub) begin
      put_byte({DEV, 1'b0}, ack); chk(ack, "R2", "address ACK", ack, 1);
      put_byte(sub, ack);         chk(ack, "R3", "pointer ACK", ack, 1);
      exp_ptr = sub[6:0]; exp_inc = sub[7];
      bus_start();
    end
    put_byte({DEV, 1'b1}, ack); chk(ack, "R6", "read address ACK", ack, 1);
    for (int k = 0; k < n; k++) begin
      get_byte(v, k < n - 1);
      chk(v == exp_mem[exp_ptr], req, "read byte", v, exp_mem[exp_ptr]);
      if (exp_inc) exp_ptr = exp_ptr + 7'd1;
    end
    wq_();
    chk(!sda_oe, "R6", "released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_err++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    bit ack;
    for (int i = 0; i < 128; i++) exp_mem[i] = init_val(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!sda_oe, "R1", "sda_oe after reset", sda_oe, 0);
    chk(!reg_we, "R1", "reg_we after reset", reg_we, 0);

    // R2: foreign address stays silent
    bus_start();
    put_byte({7'h15, 1'b0}, ack); chk(!ack, "R2", "foreign address NACK", ack, 0);
    put_byte(8'h00, ack);         chk(!ack, "R2", "silent after NACK", ack, 0);
    bus_stop();

    txn_write("R3", 8'h10, 1, 8'hA5, 8'h00, 8'h00);
    txn_write("R4", 8'h20, 3, 8'h01, 8'h02, 8'h03);
    txn_write("R5", 8'hFE, 3, 8'h11, 8'h22, 8'h33);   // 7E,7F,00
    txn_read("R6", 1'b1, 8'h10, 1);
    txn_read("R4", 1'b1, 8'h20, 2);
    txn_read("R5", 1'b1, 8'hFF, 3);                   // 7F,00,01
    txn_read("R7", 1'b0, 8'h00, 2);                   // continues at 02

    // R8: START cuts an address byte
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    c_sda_low = 1'b0; wq_();
    txn_write("R8", 8'h40, 1, 8'h77, 8'h00, 8'h00);

    // R8: STOP cuts a data byte; nothing may be written
    bus_start();
    put_byte({DEV, 1'b0}, ack); chk(ack, "R2", "address ACK", ack, 1);
    put_byte(8'h30, ack);       chk(ack, "R3", "pointer ACK", ack, 1);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
    bus_stop();
    txn_read("R8", 1'b1, 8'h30, 1);

    chk(viol == 0, "R9", "sda_oe moved while SCL high", viol, 0);
    chk(wq.size() == 0, "R3", "writes outstanding", wq.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule